// File: doc/BRIEF.md
# Entropy Register Block with Seed-Fault Recovery

This block presents a random-number source to software as three 32-bit registers on a simple request/response bus: a control register, a status register and a data register. A sampling strobe, derived from the clock by a power-of-two divider, clocks a linear feedback shift register. The shift register stands in for the noise source. Each strobe yields one 32-bit word, and the words collect in a four-word output buffer. The status register reports when at least one word is waiting. Each read of the data register takes one word from the buffer.

A pin reports a fault in the noise source. On a fault the block stops producing words and empties its buffer. It then shows a live seed-fault bit and a latched seed-fault bit. There are two build variants for recovery. The variant with a conditioning reset lets software start a reset cycle by writing a control bit to 1 and then to 0. The bit stays at 1 until the cycle ends. If the fault input goes away while no conditioning reset is armed, the block runs the same cycle by itself and leaves only the latched bit set. The variant without a conditioning reset waits for software to clear the latched bit. Software must then throw away twelve data reads before new words arrive. A second pin reports a clock fault. That fault is latched the same way, and a control bit can mask it.

Top module: `trng_csr`

## Requirements
- R1: The registers sit at byte offsets 0x0 (control), 0x4 (status) and 0x8 (data). Read data appears with a valid flag in the cycle after the request. Control reads back only bit 2 (enable), bit 3 (interrupt enable, stored only), bit 5 (clock-fault mask), bits 25:8 (a configuration group) and bit 30 (conditioning reset). All other bits read 0.
- R2: Status bit 0 (data ready) is 1 exactly while the output buffer holds at least one word. Words are produced only while the enable bit is set.
- R3: The buffer holds four 32-bit words. Each data read while ready is 1 returns the oldest word and removes it. The words are never zero, and successive words differ.
- R4: While running, an active seed-fault input stops word production and empties the buffer. It sets status bit 2 (live seed fault) and status bit 6 (latched seed fault).
- R5: In the conditioning-reset variant, writing control bit 30 as 1 arms a reset, and a later write with bit 30 as 0 starts it. Bit 30 reads 1 from arming until a cycle of RESET_SAMPLES sampling strobes ends. If the fault input is low when the cycle ends, bits 2 and 6 are both cleared and production resumes. If the fault input is still high, bit 30 clears while bits 2 and 6 stay set.
- R6: In the conditioning-reset variant, when the fault input drops with no reset armed, the block runs the reset cycle by itself. At the end, bit 2 clears, bit 6 stays set and production resumes.
- R7: Control bits 19:16 hold a divider exponent k. The sampling strobe fires once every 2^k clocks.
- R8: A data read while ready is 0 returns 0 and removes nothing.
- R9: Status bits 5 and 6 are cleared by writing 0 to them. Writing 1 to them has no effect. Bits 0, 1 and 2 ignore writes.
- R10: With control bit 5 at 0, an active clock-fault input sets status bit 1 (live) and bit 5 (latched). With control bit 5 at 1, the clock-fault input is ignored.
- R11: In the variant without a conditioning reset, bit 2 follows the fault input. After the fault, production stays stopped until bit 6 is cleared. Control bit 30 reads 0 and writes to it are ignored.
- R12: In that variant, once bit 6 is cleared with the fault gone, the next FLUSH_READS (12) data reads return 0. Production resumes after the last of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Register access request, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read request |
| bus_rvalid_o | output | 1 | Read data valid |
| seed_fault_i | input | 1 | Noise-source fault indication |
| clk_fault_i | input | 1 | Clock fault indication |

## Verification
The assertions assume three things about the inputs. Both fault pins change synchronously to the clock. The enable bit stays set while a reset cycle or a recovery is in progress, because the reset cycle counts sampling strobes. Software never writes data reads into the middle of an access: each request lasts one cycle. The bench meets these conditions by driving every input on the falling edge and issuing one single-cycle access at a time. It keeps the enable at 1 with a divider exponent of 0 through each recovery. Fault pulses last several cycles, and every check on the end of a recovery waits well beyond the eight-strobe reset cycle.

// File: rtl/trng_pkg.sv
package trng_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_FAULT = 2'd1,
        ST_CRST  = 2'd2,
        ST_FLUSH = 2'd3
    } trng_state_e;

    localparam int unsigned OFF_CTRL = 0;
    localparam int unsigned OFF_STAT = 4;
    localparam int unsigned OFF_DATA = 8;

    // control bit positions
    localparam int unsigned CB_EN      = 2;
    localparam int unsigned CB_IE      = 3;
    localparam int unsigned CB_CKMASK  = 5;
    localparam int unsigned CB_CFG_LO  = 8;
    localparam int unsigned CB_CFG_HI  = 25;
    localparam int unsigned CB_DIV_LO  = 16;
    localparam int unsigned CB_CRST    = 30;

    // status bit positions
    localparam int unsigned SB_READY   = 0;
    localparam int unsigned SB_CK_LIVE = 1;
    localparam int unsigned SB_SD_LIVE = 2;
    localparam int unsigned SB_CK_LAT  = 5;
    localparam int unsigned SB_SD_LAT  = 6;

endpackage

// File: rtl/trng_sample_gen.sv
module trng_sample_gen #(
    parameter int unsigned       DIV_W  = 4,
    parameter int unsigned       WORD_W = 32,
    parameter logic [WORD_W-1:0] SEED   = 32'h1ACE_B00C,
    parameter logic [WORD_W-1:0] TAPS   = 32'h8020_0003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic [DIV_W-1:0]  div_i,
    output logic              sample_o,
    output logic [WORD_W-1:0] word_o
);

    localparam int unsigned CNT_W = 1 << DIV_W;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] lfsr;
    } gen_t;

    gen_t             q, d;
    logic [CNT_W-1:0] limit;
    logic             fire;

    always_comb begin
        d     = q;
        limit = (CNT_W'(1) << div_i) - CNT_W'(1);
        fire  = enable_i && (q.cnt >= limit);
        if (!enable_i || fire) begin
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + CNT_W'(1);
        end
        if (fire) begin
            d.lfsr = {1'b0, q.lfsr[WORD_W-1:1]} ^ (q.lfsr[0] ? TAPS : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{cnt: '0, lfsr: SEED};
        end else begin
            q <= d;
        end
    end

    assign sample_o = fire;
    assign word_o   = q.lfsr;

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        q.lfsr != '0); // R3

endmodule

// File: rtl/trng_word_fifo.sv
module trng_word_fifo #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush_i,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    input  logic         pop_i,
    output logic [W-1:0] dout_o,
    output logic         empty_o,
    output logic         full_o
);

    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t q, d;
    logic  do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        d       = q;
        do_push = push_i && (q.cnt != CW'(DEPTH));
        do_pop  = pop_i && (q.cnt != '0);
        if (flush_i) begin
            d.wp  = '0;
            d.rp  = '0;
            d.cnt = '0;
        end else begin
            if (do_push) begin
                d.mem[q.wp] = din_i;
                d.wp        = bump(q.wp);
            end
            if (do_pop) begin
                d.rp = bump(q.rp);
            end
            case ({do_push, do_pop})
                2'b10:   d.cnt = q.cnt + CW'(1);
                2'b01:   d.cnt = q.cnt - CW'(1);
                default: d.cnt = q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign dout_o  = q.mem[q.rp];
    assign empty_o = (q.cnt == '0);
    assign full_o  = (q.cnt == CW'(DEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o); // R8

endmodule

// File: rtl/trng_recovery_fsm.sv
module trng_recovery_fsm
    import trng_pkg::*;
#(
    parameter bit          HAS_COND_RESET = 1'b1,
    parameter int unsigned RESET_SAMPLES  = 8,
    parameter int unsigned FLUSH_READS    = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        seed_fault_i,
    input  logic        sample_i,
    input  logic        cond_wr_i,
    input  logic        cond_val_i,
    input  logic        sticky_clr_i,
    input  logic        data_rd_i,
    output trng_state_e state_o,
    output logic        seed_live_o,
    output logic        seed_latch_o,
    output logic        cond_bit_o
);

    localparam int unsigned RW = $clog2(RESET_SAMPLES + 1);
    localparam int unsigned FW = $clog2(FLUSH_READS + 1);

    typedef struct packed {
        trng_state_e   state;
        logic          cur;
        logic          sticky;
        logic          armed;
        logic          manual;
        logic [RW-1:0] rcnt;
        logic [FW-1:0] fcnt;
    } fsm_t;

    fsm_t q, d;
    logic start;

    always_comb begin
        d     = q;
        start = 1'b0;
        if (sticky_clr_i) begin
            d.sticky = 1'b0;
        end
        if (HAS_COND_RESET) begin
            start = cond_wr_i && !cond_val_i && q.armed;
            if (cond_wr_i && cond_val_i) begin
                d.armed = 1'b1;
            end
            if (start) begin
                d.armed  = 1'b0;
                d.manual = 1'b1;
            end
            case (q.state)
                ST_RUN: begin
                    if (start) begin
                        d.state = ST_CRST;
                        d.rcnt  = '0;
                    end else if (seed_fault_i) begin
                        d.state = ST_FAULT;
                        d.cur   = 1'b1;
                    end
                end
                ST_FAULT: begin
                    if (start || (!seed_fault_i && !q.armed)) begin
                        d.state = ST_CRST;
                        d.rcnt  = '0;
                    end
                end
                ST_CRST: begin
                    if (sample_i) begin
                        if (q.rcnt == RW'(RESET_SAMPLES - 1)) begin
                            d.manual = 1'b0;
                            if (q.manual || start) begin
                                d.sticky = 1'b0;
                            end
                            if (seed_fault_i) begin
                                d.state = ST_FAULT;
                                d.cur   = 1'b1;
                            end else begin
                                d.state = ST_RUN;
                                d.cur   = 1'b0;
                            end
                        end else begin
                            d.rcnt = q.rcnt + RW'(1);
                        end
                    end
                end
                default: d.state = ST_RUN;
            endcase
        end else begin
            case (q.state)
                ST_RUN: begin
                    if (seed_fault_i) begin
                        d.state = ST_FAULT;
                        d.cur   = 1'b1;
                    end
                end
                ST_FAULT: begin
                    d.cur = seed_fault_i;
                    if (!seed_fault_i && !q.sticky) begin
                        d.state = ST_FLUSH;
                        d.fcnt  = '0;
                    end
                end
                ST_FLUSH: begin
                    if (seed_fault_i) begin
                        d.state = ST_FAULT;
                        d.cur   = 1'b1;
                    end else if (data_rd_i) begin
                        if (q.fcnt == FW'(FLUSH_READS - 1)) begin
                            d.state = ST_RUN;
                        end else begin
                            d.fcnt = q.fcnt + FW'(1);
                        end
                    end
                end
                default: d.state = ST_RUN;
            endcase
        end
        d.sticky = d.sticky | d.cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_RUN, default: '0};
        end else begin
            q <= d;
        end
    end

    generate
        if (HAS_COND_RESET) begin : g_cond
            assign cond_bit_o = q.armed || ((q.state == ST_CRST) && q.manual);
        end else begin : g_nocond
            assign cond_bit_o = 1'b0;
        end
    endgenerate

    assign state_o      = q.state;
    assign seed_live_o  = q.cur;
    assign seed_latch_o = q.sticky;

    AST_CRST_ENDS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cond_bit_o) |-> ($past(q.state) == ST_CRST)); // R5
    AST_LATCH_WITH_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        seed_live_o |-> seed_latch_o); // R4
    AST_FLUSH_WAITS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_FLUSH && !data_rd_i && !seed_fault_i) |=> (q.state == ST_FLUSH)); // R12

endmodule

// File: rtl/trng_csr.sv
module trng_csr
    import trng_pkg::*;
#(
    parameter int unsigned ADDR_W         = 4,
    parameter int unsigned FIFO_WORDS     = 4,
    parameter int unsigned DIV_W          = 4,
    parameter int unsigned RESET_SAMPLES  = 8,
    parameter int unsigned FLUSH_READS    = 12,
    parameter bit          HAS_COND_RESET = 1'b1,
    parameter logic [31:0] LFSR_SEED      = 32'h1ACE_B00C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              bus_rvalid_o,
    input  logic              seed_fault_i,
    input  logic              clk_fault_i
);

    localparam int unsigned CFG_W   = CB_CFG_HI - CB_CFG_LO + 1;
    localparam int unsigned DIV_OFS = CB_DIV_LO - CB_CFG_LO;

    typedef struct packed {
        logic             en;
        logic             ie;
        logic             ckmask;
        logic [CFG_W-1:0] cfg;
        logic             ck_live;
        logic             ck_lat;
        logic [31:0]      rdata;
        logic             rvalid;
    } regs_t;

    regs_t       q, d;
    logic        ctrl_wr, stat_wr, data_rd, any_rd;
    logic        sample, fifo_push, fifo_pop, fifo_empty, fifo_full, fifo_flush;
    logic [31:0] gen_word, fifo_word, ctrl_val, stat_val;
    trng_state_e fsm_state;
    logic        seed_live, seed_latch, cond_bit;
    logic        unused_wdata_bits;

    assign unused_wdata_bits = ^{bus_wdata_i[31], bus_wdata_i[29:26], bus_wdata_i[7:6],
                                 bus_wdata_i[4], bus_wdata_i[1:0]};

    assign ctrl_wr = bus_req_i && bus_we_i && (bus_addr_i == ADDR_W'(OFF_CTRL));
    assign stat_wr = bus_req_i && bus_we_i && (bus_addr_i == ADDR_W'(OFF_STAT));
    assign any_rd  = bus_req_i && !bus_we_i;
    assign data_rd = any_rd && (bus_addr_i == ADDR_W'(OFF_DATA));

    trng_sample_gen #(
        .DIV_W  (DIV_W),
        .WORD_W (32),
        .SEED   (LFSR_SEED)
    ) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (q.en),
        .div_i    (q.cfg[DIV_OFS +: DIV_W]),
        .sample_o (sample),
        .word_o   (gen_word)
    );

    trng_recovery_fsm #(
        .HAS_COND_RESET (HAS_COND_RESET),
        .RESET_SAMPLES  (RESET_SAMPLES),
        .FLUSH_READS    (FLUSH_READS)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .seed_fault_i (seed_fault_i),
        .sample_i     (sample),
        .cond_wr_i    (ctrl_wr),
        .cond_val_i   (bus_wdata_i[CB_CRST]),
        .sticky_clr_i (stat_wr && !bus_wdata_i[SB_SD_LAT]),
        .data_rd_i    (data_rd),
        .state_o      (fsm_state),
        .seed_live_o  (seed_live),
        .seed_latch_o (seed_latch),
        .cond_bit_o   (cond_bit)
    );

    assign fifo_flush = (fsm_state != ST_RUN);
    assign fifo_push  = sample && (fsm_state == ST_RUN) && !seed_fault_i && !fifo_full;
    assign fifo_pop   = data_rd && !fifo_empty;

    trng_word_fifo #(
        .DEPTH (FIFO_WORDS),
        .W     (32)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (fifo_flush),
        .push_i  (fifo_push),
        .din_i   (gen_word),
        .pop_i   (fifo_pop),
        .dout_o  (fifo_word),
        .empty_o (fifo_empty),
        .full_o  (fifo_full)
    );

    assign ctrl_val = {1'b0, cond_bit, 4'b0, q.cfg, 2'b0, q.ckmask, 1'b0, q.ie, q.en, 2'b0};
    assign stat_val = {25'b0, seed_latch, q.ck_lat, 2'b0, seed_live, q.ck_live, !fifo_empty};

    always_comb begin
        d = q;
        if (ctrl_wr) begin
            d.en     = bus_wdata_i[CB_EN];
            d.ie     = bus_wdata_i[CB_IE];
            d.ckmask = bus_wdata_i[CB_CKMASK];
            d.cfg    = bus_wdata_i[CB_CFG_HI:CB_CFG_LO];
        end
        d.ck_live = clk_fault_i && !q.ckmask;
        if (stat_wr && !bus_wdata_i[SB_CK_LAT]) begin
            d.ck_lat = 1'b0;
        end
        d.ck_lat = d.ck_lat | d.ck_live;
        d.rvalid = any_rd;
        if (any_rd) begin
            case (bus_addr_i)
                ADDR_W'(OFF_CTRL): d.rdata = ctrl_val;
                ADDR_W'(OFF_STAT): d.rdata = stat_val;
                ADDR_W'(OFF_DATA): d.rdata = fifo_empty ? 32'h0 : fifo_word;
                default:           d.rdata = 32'h0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign bus_rdata_o  = q.rdata;
    assign bus_rvalid_o = q.rvalid;

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && fifo_empty) |=> (bus_rdata_o == 32'h0)); // R8
    AST_HALT_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state != ST_RUN) |=> fifo_empty); // R4
    AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        any_rd |=> bus_rvalid_o); // R1

endmodule

// File: tb/trng_csr_tb.sv
`timescale 1ns/1ps
module trng_csr_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req0 = 1'b0, req1 = 1'b0, we = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata0, rdata1;
    logic        rv0, rv1;
    logic        sf0 = 1'b0, sf1 = 1'b0, cf0 = 1'b0, cf1 = 1'b0;
    int          errors = 0;
    int          checks = 0;

    always #2 clk = ~clk;

    trng_csr u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req_i(req0), .bus_we_i(we), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata0), .bus_rvalid_o(rv0),
        .seed_fault_i(sf0), .clk_fault_i(cf0)
    );

    trng_csr #(.HAS_COND_RESET(1'b0)) u_dut_flush (
        .clk(clk), .rst_n(rst_n), .bus_req_i(req1), .bus_we_i(we), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata1), .bus_rvalid_o(rv1),
        .seed_fault_i(sf1), .clk_fault_i(cf1)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input bit sel, input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        addr = a; wdata = v; we = 1'b1;
        if (sel) req1 = 1'b1; else req0 = 1'b1;
        @(negedge clk);
        req0 = 1'b0; req1 = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input bit sel, input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a; we = 1'b0;
        if (sel) req1 = 1'b1; else req0 = 1'b1;
        @(negedge clk);
        v = sel ? rdata1 : rdata0;
        if (!(sel ? rv1 : rv0)) begin
            checks++; errors++;
            $display("FAIL R1 read valid actual=0 expected=1");
        end
        req0 = 1'b0; req1 = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(0, 4'h0, v); check("R1 control after reset", v, 32'h0);
        rd(0, 4'h4, v); check("R2 status after reset", v, 32'h0);
        rd(0, 4'h8, v); check("R8 data read while not ready", v, 32'h0);
    endtask

    task automatic t_ctrl_mask;
        logic [31:0] v;
        wr(0, 4'h0, 32'hBFFF_FFFF);
        rd(0, 4'h0, v); check("R1 control writable mask", v, 32'h03FF_FF2C);
        wr(0, 4'h0, 32'h0);
        rd(0, 4'h0, v); check("R1 control cleared", v, 32'h0);
    endtask

    task automatic t_fill_drain;
        logic [31:0] v, w0, w1, w2, w3;
        wr(0, 4'h0, 32'h4);
        idle(10);
        rd(0, 4'h4, v); check("R2 ready once enabled", v, 32'h1);
        wr(0, 4'h0, 32'h0);
        rd(0, 4'h8, w0); rd(0, 4'h8, w1); rd(0, 4'h8, w2); rd(0, 4'h8, w3);
        check("R3 words nonzero", {31'b0, (w0 != 0) && (w1 != 0) && (w2 != 0) && (w3 != 0)}, 32'h1);
        check("R3 words differ", {31'b0, (w0 != w1) && (w1 != w2) && (w2 != w3)}, 32'h1);
        rd(0, 4'h4, v); check("R3 four words then empty", v, 32'h0);
        rd(0, 4'h8, v); check("R8 fifth read returns zero", v, 32'h0);
        rd(0, 4'h4, v); check("R8 empty read pops nothing", v, 32'h0);
    endtask

    task automatic t_divider;
        logic [31:0] v;
        wr(0, 4'h0, 32'h000F_0004);
        idle(1000);
        rd(0, 4'h4, v); check("R7 exponent 15 no sample in 1000 clocks", v, 32'h0);
        wr(0, 4'h0, 32'h0000_0004);
        idle(10);
        rd(0, 4'h4, v); check("R7 exponent 0 samples at once", v, 32'h1);
    endtask

    task automatic t_cond_reset;
        logic [31:0] v;
        @(negedge clk); sf0 = 1'b1;
        idle(3);
        rd(0, 4'h4, v); check("R4 fault sets live and latched, empties buffer", v, 32'h44);
        rd(0, 4'h8, v); check("R4 no data during fault", v, 32'h0);
        wr(0, 4'h0, 32'h4000_0004);
        rd(0, 4'h0, v); check("R5 armed bit reads one", v, 32'h4000_0004);
        wr(0, 4'h0, 32'h0000_0004);
        rd(0, 4'h0, v); check("R5 bit holds during reset cycle", v, 32'h4000_0004);
        @(negedge clk); sf0 = 1'b0;
        idle(20);
        rd(0, 4'h0, v); check("R5 bit clears after cycle", v, 32'h4);
        rd(0, 4'h4, v); check("R5 both seed bits cleared, data back", v, 32'h1);
    endtask

    task automatic t_persist_auto;
        logic [31:0] v;
        @(negedge clk); sf0 = 1'b1;
        idle(3);
        wr(0, 4'h0, 32'h4000_0004);
        wr(0, 4'h0, 32'h0000_0004);
        idle(20);
        rd(0, 4'h0, v); check("R5 bit clears with fault still present", v, 32'h4);
        rd(0, 4'h4, v); check("R5 seed bits stay while fault persists", v, 32'h44);
        @(negedge clk); sf0 = 1'b0;
        idle(20);
        rd(0, 4'h4, v); check("R6 automatic reset keeps latched bit only", v, 32'h41);
        wr(0, 4'h4, 32'hFFFF_FFFF);
        rd(0, 4'h4, v); check("R9 writing ones changes nothing", v, 32'h41);
        wr(0, 4'h4, 32'h0);
        rd(0, 4'h4, v); check("R9 writing zero clears latched bit", v, 32'h1);
    endtask

    task automatic t_clock_fault;
        logic [31:0] v;
        @(negedge clk); cf0 = 1'b1;
        idle(3);
        rd(0, 4'h4, v); check("R10 clock fault live and latched", v, 32'h23);
        @(negedge clk); cf0 = 1'b0;
        idle(2);
        rd(0, 4'h4, v); check("R10 live clears, latched stays", v, 32'h21);
        wr(0, 4'h4, 32'h0000_0040);
        rd(0, 4'h4, v); check("R9 clock latch cleared by zero", v, 32'h1);
        wr(0, 4'h0, 32'h24);
        @(negedge clk); cf0 = 1'b1;
        idle(3);
        rd(0, 4'h4, v); check("R10 masked clock fault ignored", v, 32'h1);
        @(negedge clk); cf0 = 1'b0;
    endtask

    task automatic t_flush_variant;
        logic [31:0] v;
        wr(1, 4'h0, 32'h4);
        idle(10);
        rd(1, 4'h4, v); check("R2 second variant ready", v, 32'h1);
        @(negedge clk); sf1 = 1'b1;
        idle(3);
        @(negedge clk); sf1 = 1'b0;
        idle(2);
        rd(1, 4'h4, v); check("R11 live follows input, latched held", v, 32'h40);
        idle(20);
        rd(1, 4'h4, v); check("R11 stays stopped until latch cleared", v, 32'h40);
        wr(1, 4'h0, 32'h4000_0004);
        rd(1, 4'h0, v); check("R11 conditioning bit ignored", v, 32'h4);
        wr(1, 4'h4, 32'h0);
        for (int i = 0; i < 11; i++) begin
            rd(1, 4'h8, v); check("R12 discarded read returns zero", v, 32'h0);
        end
        idle(4);
        rd(1, 4'h4, v); check("R12 still stopped before last discard", v, 32'h0);
        rd(1, 4'h8, v); check("R12 last discarded read", v, 32'h0);
        idle(5);
        rd(1, 4'h4, v); check("R12 production resumes", v, 32'h1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_ctrl_mask();
        t_fill_drain();
        t_divider();
        t_cond_reset();
        t_persist_auto();
        t_clock_fault();
        t_flush_variant();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule